// File: doc/BRIEF.md
# Window Watchdog with Shared Reset Output

This block supervises an external microcontroller with a windowed watchdog. The host controls it through one register bit, modelled here as a write strobe with a single data bit. Writing the bit as 1 while the watchdog is off switches it on and starts the first service interval at that write. While the watchdog is on, each further write of 1 services it and restarts the interval. A write of 0 switches it off.

A service write must land inside a window: not before `WIN_MIN` cycles and not after `WIN_MAX` cycles since the previous enable or service write. If it lands too early, or if the interval runs out without one, the block pulls its active-low reset request low for `RST_WIDTH` cycles. This is a fixed internal stretch that stands in for the pull-up delay on the board. The same output carries the power-on reset pulse of `POR_CYCLES` cycles after the supply comes up. A sticky warm-boot flag records that the last reset came from the watchdog. A status read clears it, and so does a power-on reset. After a watchdog reset the enable bit is cleared.

The sequencer has four states:
- `ST_POR`: power-on pulse.
- `ST_OFF`: watchdog disabled.
- `ST_ARMED`: interval running.
- `ST_BITE`: watchdog reset pulse.

It has these transitions:
- POR done: `ST_POR` to `ST_OFF`, after `POR_CYCLES`.
- enable: `ST_OFF` to `ST_ARMED`, on a write of 1.
- service: `ST_ARMED` to `ST_ARMED`, on a write of 1 inside the window.
- disable: `ST_ARMED` to `ST_OFF`, on a write of 0.
- early bite: `ST_ARMED` to `ST_BITE`, on a write of 1 before `WIN_MIN`.
- late bite: `ST_ARMED` to `ST_BITE`, when `WIN_MAX` is reached without a service.
- pulse done: `ST_BITE` to `ST_OFF`, after `RST_WIDTH`.

Elaboration stops if `WIN_MIN` is not smaller than `WIN_MAX`.

Top module: `win_wdog_ctrl`

## Requirements
- R1: After `supply_rst_n` is released, `host_rst_n` stays low for exactly `POR_CYCLES` clock cycles and then goes high. While the supply reset is low, `warm_boot` is 0.
- R2: A write of 1 while the watchdog is off (`wr_stb`=1, `wr_bit`=1 at a clock edge) enables it. The first interval is counted from that edge.
- R3: A write of 0 (`wr_stb`=1, `wr_bit`=0) while armed disables the watchdog. No reset is produced while it is off, however long it stays off.
- R4: A write of 1 that arrives k edges after the previous enable or service write, with `WIN_MIN` <= k <= `WIN_MAX`, causes no reset and restarts the interval from that edge.
- R5: A write of 1 that arrives k edges after the previous enable or service write, with k < `WIN_MIN`, drives `host_rst_n` low from that edge.
- R6: Without a service write, `host_rst_n` goes low at the edge `WIN_MAX` edges after the last enable or service write. It is still high one edge before that.
- R7: A watchdog reset holds `host_rst_n` low for exactly `RST_WIDTH` cycles.
- R8: `warm_boot` goes to 1 at the same edge that starts a watchdog reset. It stays 1 until an edge with `rd_stb`=1 and no new watchdog reset, or until a supply reset. A watchdog reset wins over a read at the same edge.
- R9: After a watchdog reset pulse ends, the watchdog is off and produces no further reset until it is enabled again.
- R10: Writes that arrive while `host_rst_n` is low, during the power-on pulse or a watchdog pulse, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supply_rst_n | input | 1 | Asynchronous active-low supply-up reset |
| wr_stb | input | 1 | Write strobe for the enable bit |
| wr_bit | input | 1 | Enable bit value written with `wr_stb` |
| rd_stb | input | 1 | Status read strobe; clears `warm_boot` |
| host_rst_n | output | 1 | Active-low reset request to the host (power-on and watchdog) |
| warm_boot | output | 1 | Sticky flag: last reset came from the watchdog |

## Verification
The main stimulus is a sweep of the service write's arrival over every distance k from 1 to `WIN_MAX` edges after enable. This separates the early-fault range from the accepted window, with both window edges included. Each accepted service is followed by a silent interval, which shows whether the interval really restarted at the service edge rather than at enable. A disable followed by a long quiet stretch, writes made during both kinds of reset pulse, and a read at the same edge as an early bite cover the paths that must have no effect or must win over one another.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_POR   = 2'd0,
        ST_OFF   = 2'd1,
        ST_ARMED = 2'd2,
        ST_BITE  = 2'd3
    } wdog_state_e;
endpackage

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    // Counts edges since the last restart; value 1 on the first edge after it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= CW'(1);
        end else if (restart) begin
            count <= CW'(1);
        end else if (count != CMAX) begin
            count <= count + CW'(1);
        end
    end
endmodule

// File: rtl/wdog_boot_flag.sv
module wdog_boot_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_clr,
    output logic warm
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= 1'b0;
        end else if (set_evt) begin
            warm <= 1'b1;
        end else if (rd_clr) begin
            warm <= 1'b0;
        end
    end

    // R8: a bite sets the flag, a read without a bite clears it
    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> warm);
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !set_evt) |=> !warm);
    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && !set_evt) |=> $stable(warm));
endmodule

// File: rtl/wdog_seq_fsm.sv
module wdog_seq_fsm
    import wdog_pkg::*;
#(
    parameter int POR_CYCLES = 6,
    parameter int WIN_MIN    = 4,
    parameter int WIN_MAX    = 10,
    parameter int RST_WIDTH  = 5,
    parameter int CW         = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic          wr_bit,
    input  logic [CW-1:0] count,
    output logic          restart,
    output logic          bite,
    output logic          host_rst_n
);
    localparam logic [CW-1:0] C_POR  = CW'(POR_CYCLES);
    localparam logic [CW-1:0] C_MIN  = CW'(WIN_MIN);
    localparam logic [CW-1:0] C_MAX  = CW'(WIN_MAX);
    localparam logic [CW-1:0] C_BITE = CW'(RST_WIDTH);

    wdog_state_e st, nxt;
    logic        svc_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_POR;
        end else begin
            st <= nxt;
        end
    end

    // next state and counter control
    always_comb begin
        nxt    = st;
        svc_ok = 1'b0;
        unique case (st)
            ST_POR: begin
                if (count == C_POR) nxt = ST_OFF;
            end
            ST_OFF: begin
                if (wr_stb && wr_bit) nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (wr_stb && !wr_bit) begin
                    nxt = ST_OFF;
                end else if (wr_stb) begin
                    if (count < C_MIN) nxt = ST_BITE;
                    else               svc_ok = 1'b1;
                end else if (count >= C_MAX) begin
                    nxt = ST_BITE;
                end
            end
            ST_BITE: begin
                if (count == C_BITE) nxt = ST_OFF;
            end
            default: nxt = ST_POR;
        endcase
        restart = svc_ok || (nxt != st);
        bite    = (st == ST_ARMED) && (nxt == ST_BITE);
    end

    // outputs
    always_comb begin
        host_rst_n = !((st == ST_POR) || (st == ST_BITE));
    end

    assert_por_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_POR && count < C_POR) |=> (st == ST_POR));
    assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF) |=> (st != ST_BITE));
    assert_svc_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && wr_stb && wr_bit && count >= C_MIN)
        |=> (st == ST_ARMED && count == CW'(1)));
    assert_early_bite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && wr_stb && wr_bit && count < C_MIN) |=> !host_rst_n);
    assert_late_bite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && !wr_stb && count >= C_MAX) |=> !host_rst_n);
    assert_bite_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BITE && count < C_BITE) |=> (st == ST_BITE));
    assert_bite_ends_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BITE && count == C_BITE) |=> (st == ST_OFF));
endmodule

// File: rtl/win_wdog_ctrl.sv
module win_wdog_ctrl #(
    parameter int POR_CYCLES = 6,
    parameter int WIN_MIN    = 4,
    parameter int WIN_MAX    = 10,
    parameter int RST_WIDTH  = 5
) (
    input  logic clk,
    input  logic supply_rst_n,
    input  logic wr_stb,
    input  logic wr_bit,
    input  logic rd_stb,
    output logic host_rst_n,
    output logic warm_boot
);
    localparam int BIG1 = (POR_CYCLES > WIN_MAX) ? POR_CYCLES : WIN_MAX;
    localparam int BIG  = (BIG1 > RST_WIDTH) ? BIG1 : RST_WIDTH;
    localparam int CW   = $clog2(BIG + 2);

    // window ordering is checked at elaboration
    if (!(WIN_MIN >= 1 && WIN_MIN < WIN_MAX)) begin : g_bad_window
        $error("win_wdog_ctrl: need 1 <= WIN_MIN < WIN_MAX");
    end

    logic [CW-1:0] count;
    logic          restart;
    logic          bite;

    wdog_tick_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (supply_rst_n),
        .restart (restart),
        .count   (count)
    );

    wdog_seq_fsm #(
        .POR_CYCLES (POR_CYCLES),
        .WIN_MIN    (WIN_MIN),
        .WIN_MAX    (WIN_MAX),
        .RST_WIDTH  (RST_WIDTH),
        .CW         (CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (supply_rst_n),
        .wr_stb     (wr_stb),
        .wr_bit     (wr_bit),
        .count      (count),
        .restart    (restart),
        .bite       (bite),
        .host_rst_n (host_rst_n)
    );

    wdog_boot_flag u_flag (
        .clk     (clk),
        .rst_n   (supply_rst_n),
        .set_evt (bite),
        .rd_clr  (rd_stb),
        .warm    (warm_boot)
    );

    assert_warm_with_pulse_R8: assert property (@(posedge clk) disable iff (!supply_rst_n)
        (host_rst_n && !warm_boot) ##1 !host_rst_n |-> warm_boot);
endmodule

// File: tb/win_wdog_ctrl_tb.sv
`timescale 1ns/1ps
module win_wdog_ctrl_tb;
    localparam int POR_CYCLES = 6;
    localparam int WIN_MIN    = 4;
    localparam int WIN_MAX    = 10;
    localparam int RST_WIDTH  = 5;

    logic clk = 1'b0;
    logic supply_rst_n = 1'b0;
    logic wr_stb = 1'b0;
    logic wr_bit = 1'b0;
    logic rd_stb = 1'b0;
    logic host_rst_n;
    logic warm_boot;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    win_wdog_ctrl #(
        .POR_CYCLES (POR_CYCLES),
        .WIN_MIN    (WIN_MIN),
        .WIN_MAX    (WIN_MAX),
        .RST_WIDTH  (RST_WIDTH)
    ) u_dut (
        .clk          (clk),
        .supply_rst_n (supply_rst_n),
        .wr_stb       (wr_stb),
        .wr_bit       (wr_bit),
        .rd_stb       (rd_stb),
        .host_rst_n   (host_rst_n),
        .warm_boot    (warm_boot)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one strobe cycle, sampled at the next rising edge
    task automatic bus(input bit w, input bit d, input bit r);
        wr_stb = w; wr_bit = d; rd_stb = r;
        @(negedge clk);
        wr_stb = 1'b0; wr_bit = 1'b0; rd_stb = 1'b0;
    endtask

    // counts low cycles starting at the current negedge
    task automatic count_low(output int n);
        n = 0;
        while (!host_rst_n && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic clear_flag;
        bus(1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        int n;
        @(negedge clk);
        chk("R1 flag in supply reset", int'(warm_boot), 0);
        chk("R1 output in supply reset", int'(host_rst_n), 0);
        supply_rst_n = 1'b1;
        count_low(n);
        chk("R1 power-on width", n, POR_CYCLES);

        // R10: write during power-on pulse ignored
        supply_rst_n = 1'b0;
        idle(1);
        supply_rst_n = 1'b1;
        bus(1'b1, 1'b1, 1'b0);
        idle(POR_CYCLES + WIN_MAX + 4);
        chk("R10 write in power-on ignored", int'(host_rst_n), 1);

        // sweep service distance k from enable (R2, R4, R5, R6, R7, R8, R9)
        for (int k = 1; k <= WIN_MAX; k++) begin
            bus(1'b1, 1'b1, 1'b0);
            idle(k - 1);
            chk("R2 armed before service", int'(host_rst_n), 1);
            bus(1'b1, 1'b1, 1'b0);
            if (k < WIN_MIN) begin
                chk("R5 early service bites", int'(host_rst_n), 0);
                chk("R8 flag set on bite", int'(warm_boot), 1);
                count_low(n);
                chk("R7 early pulse width", n, RST_WIDTH);
            end else begin
                chk("R4 in-window no reset", int'(host_rst_n), 1);
                chk("R4 no flag", int'(warm_boot), 0);
                idle(WIN_MAX - 1);
                chk("R4 interval restarted", int'(host_rst_n), 1);
                idle(1);
                chk("R6 timeout bites", int'(host_rst_n), 0);
                count_low(n);
                chk("R7 late pulse width", n, RST_WIDTH);
            end
            idle(WIN_MAX + 3);
            chk("R9 off after bite", int'(host_rst_n), 1);
            chk("R8 flag held", int'(warm_boot), 1);
            clear_flag();
            chk("R8 read clears flag", int'(warm_boot), 0);
        end

        // R6 straight from enable, boundary
        bus(1'b1, 1'b1, 1'b0);
        idle(WIN_MAX - 1);
        chk("R6 one before limit", int'(host_rst_n), 1);
        idle(1);
        chk("R6 at limit", int'(host_rst_n), 0);
        // R10: writes during watchdog pulse ignored
        bus(1'b1, 1'b1, 1'b0);
        bus(1'b1, 1'b0, 1'b0);
        bus(1'b1, 1'b1, 1'b0);
        count_low(n);
        chk("R10 pulse width with writes", n, RST_WIDTH - 3);
        idle(WIN_MAX + 3);
        chk("R10 write in pulse ignored", int'(host_rst_n), 1);
        clear_flag();

        // R3: disable then long quiet
        bus(1'b1, 1'b1, 1'b0);
        idle(3);
        bus(1'b1, 1'b0, 1'b0);
        idle(WIN_MAX * 4);
        chk("R3 disabled stays quiet", int'(host_rst_n), 1);
        chk("R3 no flag", int'(warm_boot), 0);

        // R8: read at same edge as early bite
        bus(1'b1, 1'b1, 1'b0);
        bus(1'b1, 1'b1, 1'b1);
        chk("R8 bite wins over read", int'(warm_boot), 1);
        count_low(n);
        idle(2);
        // R8 and R1: supply reset clears the flag
        supply_rst_n = 1'b0;
        idle(1);
        chk("R8 supply reset clears flag", int'(warm_boot), 0);
        supply_rst_n = 1'b1;
        count_low(n);
        chk("R1 second power-on width", n, POR_CYCLES);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule